// File: doc/BRIEF.md
# Sv39 Page Table Walker

This block translates one 39-bit virtual address by walking a three-level Sv39 page table in memory. A single `start` pulse captures the request:

- the virtual address;
- the access kind (fetch, load or store);
- the privilege mode;
- the make-executable-readable and supervisor-user-access flags;
- the physical base of the root table;
- the level at which the walk begins.

While the walk runs, `busy` stays high. The walker issues 8-byte table reads on a ready/valid request port and takes each entry back on a response port that carries an error flag.

Every fetched entry is classified as invalid, pointer or leaf. A pointer moves the walk one level down. A leaf is checked against the access rules and, when it maps a superpage, against its alignment. The walk ends with a one-cycle `done` pulse. The result fields are either a success record or a distinct fault code.

A success record holds:

- the physical address, with virtual-page bits merged in for superpages;
- the leaf entry;
- the address of the leaf entry;
- the level of the leaf;
- the global flag gathered along the path.

A surrounding translation cache or core feeds the walker one miss at a time and reads the record when `done` rises.

Top module: `sv39_walker`

## Requirements
- R1: Each table read asks for address base + 8 × ((VPN >> 9·level) mod 512), where VPN is vaddr[38:12]. The first read uses `req_root` and `req_level`; a `req_level` of 3 is treated as 2.
- R2: An entry is decoded from bit 0 upward as V, R, W, X, U, G, A, D. Its PPN is bits 53:10. An entry with V=0, or with W=1 and R=0, ends the walk with fault code 1.
- R3: An entry with V=1 and R=W=X=0 is a pointer. At level 0 it ends the walk with fault code 1. At a higher level, the next read uses base PPN·4096 at level − 1.
- R4: A leaf that fails the access rules ends the walk with fault code 2.
  - Access kind: `req_acc` 00 is fetch and needs X. 01 is load and needs R, or X when `req_mxr` is 1. 1x is store and needs W.
  - User mode: with `req_priv_s`=0 the leaf must have U=1.
  - Supervisor mode: a U=1 leaf is allowed only for load or store with `req_sum`=1.
- R5: A leaf that passes R4 at level L>0 ends the walk with fault code 3 when the low 9·L bits of its PPN are not all zero.
- R6: On success (fault code 0), `res_paddr` = {PPN | (VPN mod 2^(9·L)), vaddr[11:0]}.
- R7: On success, the result carries the following, and `res_global` holds the OR of the G bits of every pointer and of the leaf on the path:
  - `res_pte`, the leaf entry;
  - `res_pte_addr`, the address of the leaf entry;
  - `res_level`, the level L of the leaf.
- R8: A response with `mem_rsp_err`=1 ends the walk with fault code 4.
- R9: Timing of the request port and of `busy`:
  - `busy` is high from the cycle after an accepted `start` up to the `done` cycle.
  - A `start` while busy is ignored.
  - A read request holds its address until `mem_rd_ready` is seen.
  - No read is issued while idle.
- R10: `done` pulses for one cycle, in the cycle after the response that ends the walk. The fault code and result fields then hold until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| req_vaddr | input | 39 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 fetch, 01 load, 1x store |
| req_priv_s | input | 1 | 1 = supervisor, 0 = user |
| req_mxr | input | 1 | Loads may use executable pages |
| req_sum | input | 1 | Supervisor may load/store user pages |
| req_root | input | 56 | Physical base of the root table |
| req_level | input | 2 | Starting level (0..2) |
| busy | output | 1 | Walk in progress |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 56 | Table entry address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_err | input | 1 | Read response is an access error |
| mem_rsp_data | input | 64 | Table entry returned |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault_code | output | 3 | 0 ok, 1 invalid, 2 permission, 3 misaligned, 4 access |
| res_paddr | output | 56 | Translated physical address |
| res_pte | output | 64 | Leaf entry |
| res_pte_addr | output | 56 | Address of the leaf entry |
| res_level | output | 2 | Level of the leaf |
| res_global | output | 1 | Accumulated global flag |

## Verification
The bench targets the following corner cases and the wrong result each would produce:

- **Pointer at level 0.** A walker that ignored it would fetch past the last level.
- **Superpage with a stray low PPN bit.** A walker that skipped the alignment test would report success with a corrupted address.
- **Superpage merge.** An aligned superpage at level 1 or 2 must pick up the low VPN bits. Wrong masking shows up as a wrong physical address.
- **Access rules.** The cases are a supervisor fetch from a user page, execute-only pages with and without MXR, and SUM-gated loads. A slip in the rules turns a fault into a success or the reverse.
- **Index slicing.** An off-by-one in the 9-bit index produces a read address that differs from the one the bench expects.
- **Global flag.** Collecting G only from the leaf, and not from the pointers above it, gives a wrong `res_global`.
- **Stray start and error timing.** A start pulse during a walk, and error responses at different depths, expose a walker that restarts or keeps fetching.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int VA_W     = 39;
  parameter int PA_W     = 56;
  parameter int PG_BITS  = 12;
  parameter int LVL_BITS = 9;
  parameter int LEVELS   = 3;
  parameter int PTE_W    = 64;
  parameter int PTE_LOG  = 3;
  localparam int VPN_W   = VA_W - PG_BITS;
  localparam int PPN_W   = PA_W - PG_BITS;
  localparam int LVL_W   = $clog2(LEVELS + 1);
  localparam int OFS_W   = LVL_BITS + PTE_LOG;
  localparam int PPN_LSB = 10;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_INVALID  = 3'd1,
    FLT_PERM     = 3'd2,
    FLT_MISALIGN = 3'd3,
    FLT_ACCESS   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_state_e;

  localparam logic [1:0] ACC_FETCH = 2'b00;

  // byte offset of the entry selected at one level
  function automatic logic [OFS_W-1:0] ptw_entry_ofs(input logic [VPN_W-1:0] vpn,
                                                     input logic [LVL_W-1:0] lvl);
    logic [VPN_W-1:0] sh;
    sh = vpn >> (LVL_BITS * int'(lvl));
    return {sh[LVL_BITS-1:0], {PTE_LOG{1'b0}}};
  endfunction

  // low PPN bits covered by a superpage at this level
  function automatic logic [PPN_W-1:0] ptw_sp_mask(input logic [LVL_W-1:0] lvl);
    logic [PPN_W-1:0] one;
    one = {{(PPN_W-1){1'b0}}, 1'b1};
    return (one << (LVL_BITS * int'(lvl))) - one;
  endfunction

  function automatic logic ptw_perm_ok(input logic r, input logic w, input logic x,
                                       input logic u, input logic [1:0] acc,
                                       input logic priv_s, input logic mxr,
                                       input logic sum);
    logic kind_ok;
    logic mode_ok;
    if (acc[1])      kind_ok = w;
    else if (acc[0]) kind_ok = r | (mxr & x);
    else             kind_ok = x;
    if (!priv_s)     mode_ok = u;
    else if (u)      mode_ok = sum & (acc != ACC_FETCH);
    else             mode_ok = 1'b1;
    return kind_ok & mode_ok;
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen import ptw_pkg::*; (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  entry_addr
);
  logic [OFS_W-1:0] ofs;
  assign ofs        = ptw_entry_ofs(vpn, lvl);
  assign entry_addr = base + {{(PA_W-OFS_W){1'b0}}, ofs};
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval import ptw_pkg::*; (
  input  logic [PTE_W-1:0]   pte,
  input  logic [LVL_W-1:0]   lvl,
  input  logic [1:0]         acc,
  input  logic               priv_s,
  input  logic               mxr,
  input  logic               sum,
  input  logic [VPN_W-1:0]   vpn,
  input  logic [PG_BITS-1:0] pg_ofs,
  output logic               is_invalid,
  output logic               is_ptr,
  output logic               perm_ok,
  output logic               misaligned,
  output logic               glob_bit,
  output logic [PA_W-1:0]    leaf_paddr,
  output logic [PA_W-1:0]    next_base
);
  logic f_v, f_r, f_w, f_x, f_u;
  logic [PPN_W-1:0] ppn;
  logic [PPN_W-1:0] mask;
  logic [PPN_W-1:0] merged;
  logic unused_pte_bits;

  assign f_v      = pte[0];
  assign f_r      = pte[1];
  assign f_w      = pte[2];
  assign f_x      = pte[3];
  assign f_u      = pte[4];
  assign glob_bit = pte[5];
  assign ppn      = pte[PPN_LSB +: PPN_W];
  assign unused_pte_bits = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:6]};

  assign is_invalid = !f_v || (f_w && !f_r);
  assign is_ptr     = f_v && !f_r && !f_w && !f_x;
  assign perm_ok    = ptw_perm_ok(f_r, f_w, f_x, f_u, acc, priv_s, mxr, sum);

  assign mask       = ptw_sp_mask(lvl);
  assign misaligned = (ppn & mask) != '0;
  assign merged     = ppn | ({{(PPN_W-VPN_W){1'b0}}, vpn} & mask);
  assign leaf_paddr = {merged, pg_ofs};
  assign next_base  = {ppn, {PG_BITS{1'b0}}};
endmodule

// File: rtl/sv39_walker.sv
module sv39_walker import ptw_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_acc,
  input  logic               req_priv_s,
  input  logic               req_mxr,
  input  logic               req_sum,
  input  logic [PA_W-1:0]    req_root,
  input  logic [LVL_W-1:0]   req_level,
  output logic               busy,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               done,
  output logic [2:0]         fault_code,
  output logic [PA_W-1:0]    res_paddr,
  output logic [PTE_W-1:0]   res_pte,
  output logic [PA_W-1:0]    res_pte_addr,
  output logic [LVL_W-1:0]   res_level,
  output logic               res_global
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             priv_q, mxr_q, sum_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             glob_q;
  fault_e           fault_q;

  logic [PA_W-1:0]  entry_addr;
  logic             is_invalid, is_ptr, perm_ok, misaligned, glob_bit;
  logic [PA_W-1:0]  leaf_paddr, next_base;

  // named walk events
  logic rsp_fire, evt_access, evt_invalid, evt_descend;
  logic evt_perm, evt_misalign, evt_success, evt_finish;
  fault_e finish_code;
  logic [LVL_W-1:0] start_lvl;

  ptw_addr_gen u_addr (
    .base       (base_q),
    .vpn        (va_q[VA_W-1:PG_BITS]),
    .lvl        (lvl_q),
    .entry_addr (entry_addr)
  );

  ptw_pte_eval u_eval (
    .pte        (mem_rsp_data),
    .lvl        (lvl_q),
    .acc        (acc_q),
    .priv_s     (priv_q),
    .mxr        (mxr_q),
    .sum        (sum_q),
    .vpn        (va_q[VA_W-1:PG_BITS]),
    .pg_ofs     (va_q[PG_BITS-1:0]),
    .is_invalid (is_invalid),
    .is_ptr     (is_ptr),
    .perm_ok    (perm_ok),
    .misaligned (misaligned),
    .glob_bit   (glob_bit),
    .leaf_paddr (leaf_paddr),
    .next_base  (next_base)
  );

  assign rsp_fire     = (state_q == ST_WAIT) && mem_rsp_valid;
  assign evt_access   = rsp_fire && mem_rsp_err;
  assign evt_invalid  = rsp_fire && !mem_rsp_err && (is_invalid || (is_ptr && lvl_q == '0));
  assign evt_descend  = rsp_fire && !mem_rsp_err && is_ptr && lvl_q != '0;
  assign evt_perm     = rsp_fire && !mem_rsp_err && !is_invalid && !is_ptr && !perm_ok;
  assign evt_misalign = rsp_fire && !mem_rsp_err && !is_invalid && !is_ptr && perm_ok && misaligned;
  assign evt_success  = rsp_fire && !mem_rsp_err && !is_invalid && !is_ptr && perm_ok && !misaligned;
  assign evt_finish   = evt_access || evt_invalid || evt_perm || evt_misalign || evt_success;

  always_comb begin
    finish_code = FLT_NONE;
    if (evt_access)        finish_code = FLT_ACCESS;
    else if (evt_invalid)  finish_code = FLT_INVALID;
    else if (evt_perm)     finish_code = FLT_PERM;
    else if (evt_misalign) finish_code = FLT_MISALIGN;
  end

  assign start_lvl = (req_level > TOP_LVL) ? TOP_LVL : req_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      priv_q  <= 1'b0;
      mxr_q   <= 1'b0;
      sum_q   <= 1'b0;
      base_q  <= '0;
      lvl_q   <= '0;
      glob_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_REQ;
          va_q    <= req_vaddr;
          acc_q   <= req_acc;
          priv_q  <= req_priv_s;
          mxr_q   <= req_mxr;
          sum_q   <= req_sum;
          base_q  <= req_root;
          lvl_q   <= start_lvl;
          glob_q  <= 1'b0;
        end
        ST_REQ: if (mem_rd_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (evt_descend) begin
            state_q <= ST_REQ;
            base_q  <= next_base;
            lvl_q   <= lvl_q - 1'b1;
            glob_q  <= glob_q | glob_bit;
          end else if (evt_finish) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done         <= 1'b0;
      fault_q      <= FLT_NONE;
      res_paddr    <= '0;
      res_pte      <= '0;
      res_pte_addr <= '0;
      res_level    <= '0;
      res_global   <= 1'b0;
    end else begin
      done <= evt_finish;
      if (evt_finish) begin
        fault_q      <= finish_code;
        res_paddr    <= leaf_paddr;
        res_pte      <= mem_rsp_data;
        res_pte_addr <= entry_addr;
        res_level    <= lvl_q;
        res_global   <= glob_q | glob_bit;
      end
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign mem_rd_valid = (state_q == ST_REQ);
  assign mem_rd_addr  = entry_addr;
  assign fault_code   = fault_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R9
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> busy); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_rd_valid); // R10
  AST_LAST_LEVEL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && !mem_rsp_err && is_ptr && lvl_q == '0 |=> done && fault_code == FLT_INVALID); // R3
  AST_DESCEND_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_descend |=> mem_rd_valid && lvl_q == $past(lvl_q) - 1'b1); // R3
  AST_ACCESS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_access |=> done && fault_code == FLT_ACCESS); // R8
  AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_misalign |=> done && fault_code == FLT_MISALIGN && res_level != '0); // R5
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_code == FLT_NONE |-> res_paddr[PG_BITS-1:0] == va_q[PG_BITS-1:0]); // R6
endmodule

// File: tb/sim_sv39_walker.sv
`timescale 1ns/1ps
module sim_sv39_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [38:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_priv_s = 1'b0, req_mxr = 1'b0, req_sum = 1'b0;
  logic [55:0] req_root = '0;
  logic [1:0]  req_level = '0;
  logic        busy, mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [55:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [2:0]  fault_code;
  logic [55:0] res_paddr, res_pte_addr;
  logic [63:0] res_pte;
  logic [1:0]  res_level;
  logic        res_global;

  int checks = 0;
  int errors = 0;

  // test description
  logic [38:0] t_va;
  logic [1:0]  t_acc;
  logic        t_priv, t_mxr, t_sum;
  logic [55:0] t_root;
  logic [1:0]  t_lvl;
  int          t_err;
  logic [63:0] t_pte [3];

  // expected outcome
  logic [63:0] e_addr [3];
  int          e_steps;
  int          e_fault;
  logic [63:0] e_paddr, e_pte, e_pte_addr;
  int          e_level;
  logic        e_glob;

  always #5 clk = ~clk;

  sv39_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_priv_s(req_priv_s), .req_mxr(req_mxr),
    .req_sum(req_sum), .req_root(req_root), .req_level(req_level),
    .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data), .done(done),
    .fault_code(fault_code), .res_paddr(res_paddr), .res_pte(res_pte),
    .res_pte_addr(res_pte_addr), .res_level(res_level), .res_global(res_global)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic g, input logic u,
                                         input logic x, input logic w, input logic r,
                                         input logic v);
    return {10'd0, ppn, 2'b00, 1'b1, 1'b1, g, u, x, w, r, v};
  endfunction

  function automatic string tag_of(input int f);
    case (f)
      1: return "R2/R3";
      2: return "R4";
      3: return "R5";
      4: return "R8";
      default: return "R6";
    endcase
  endfunction

  // expected walk computed with plain arithmetic
  task automatic model();
    logic [63:0] base, vpn, idx, ppn, span, pte;
    int lvl;
    logic ok, g;
    base = {8'd0, t_root};
    vpn = {37'd0, t_va[38:12]};
    lvl = (t_lvl == 2'd3) ? 2 : int'(t_lvl);
    g = 1'b0;
    e_fault = 0;
    e_steps = 0;
    for (int s = 0; s < 3; s++) begin
      span = 64'd1 << (9 * lvl);
      idx = (vpn / span) % 512;
      e_addr[s] = base + idx * 8;
      e_steps = s + 1;
      if (t_err == s) begin e_fault = 4; return; end
      pte = t_pte[s];
      ppn = {20'd0, pte[53:10]};
      if (!pte[0] || (pte[2] && !pte[1])) begin e_fault = 1; return; end
      g = g | pte[5];
      if (!pte[1] && !pte[2] && !pte[3]) begin
        if (lvl == 0) begin e_fault = 1; return; end
        base = ppn * 4096;
        lvl = lvl - 1;
      end else begin
        if (t_acc == 2'b00) ok = pte[3];
        else if (t_acc == 2'b01) ok = pte[1] || (t_mxr && pte[3]);
        else ok = pte[2];
        if (!t_priv) ok = ok && pte[4];
        else if (pte[4]) ok = ok && (t_acc != 2'b00) && t_sum;
        if (!ok) begin e_fault = 2; return; end
        if (ppn % span != 0) begin e_fault = 3; return; end
        e_paddr = (ppn + (vpn % span)) * 4096 + {52'd0, t_va[11:0]};
        e_pte = pte;
        e_pte_addr = e_addr[s];
        e_level = lvl;
        e_glob = g;
        return;
      end
    end
  endtask

  task automatic set_req(input logic [38:0] va, input logic [1:0] acc, input logic priv,
                         input logic mxr, input logic sum, input logic [55:0] root,
                         input logic [1:0] lvl, input int err);
    t_va = va; t_acc = acc; t_priv = priv; t_mxr = mxr; t_sum = sum;
    t_root = root; t_lvl = lvl; t_err = err;
  endtask

  task automatic run_walk(input bit poke_start);
    int cyc;
    logic [2:0] held_fault;
    string tg;
    model();
    tg = tag_of(e_fault);
    @(negedge clk);
    req_vaddr = t_va; req_acc = t_acc; req_priv_s = t_priv; req_mxr = t_mxr;
    req_sum = t_sum; req_root = t_root; req_level = t_lvl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", {63'd0, busy}, 64'd1);
    for (int s = 0; s < e_steps; s++) begin
      cyc = 0;
      while (!mem_rd_valid && cyc < 50) begin @(negedge clk); cyc++; end
      chk("R1 entry address", {8'd0, mem_rd_addr}, e_addr[s]);
      repeat ($urandom % 3) @(negedge clk);
      if (poke_start && s == 0) begin
        start = 1'b1; req_vaddr = ~t_va; req_root = ~t_root;
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0; start = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_err = (t_err == s);
      mem_rsp_data = t_pte[s];
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    end
    chk("R10 done pulse", {63'd0, done}, 64'd1);
    chk({tg, " fault code"}, {61'd0, fault_code}, 64'(e_fault));
    chk("R9 busy low at done", {63'd0, busy}, 64'd0);
    if (e_fault == 0) begin
      chk("R6 physical address", {8'd0, res_paddr}, e_paddr);
      chk("R7 leaf entry", res_pte, e_pte);
      chk("R7 entry address", {8'd0, res_pte_addr}, e_pte_addr);
      chk("R7 level", {62'd0, res_level}, 64'(e_level));
      chk("R7 global", {63'd0, res_global}, {63'd0, e_glob});
    end
    held_fault = fault_code;
    @(negedge clk);
    chk("R10 done one cycle", {63'd0, done}, 64'd0);
    repeat (2) @(negedge clk);
    chk("R10 result held", {61'd0, fault_code}, {61'd0, held_fault});
    if (poke_start) begin
      chk("R9 start while busy ignored: no read", {63'd0, mem_rd_valid}, 64'd0);
      chk("R9 start while busy ignored: idle", {63'd0, busy}, 64'd0);
    end
  endtask

  task automatic gen_random();
    int kind;
    logic [43:0] ppn;
    logic [2:0] rwx;
    set_req({$urandom, $urandom} & 64'h7F_FFFF_FFFF, 2'($urandom % 3), 1'($urandom),
            1'($urandom), 1'($urandom), {$urandom, $urandom} & 64'hFF_FFFF_FFFF_F000,
            2'($urandom % 3), ($urandom % 10 == 0) ? int'($urandom % 3) : 7);
    for (int s = 0; s < 3; s++) begin
      kind = $urandom % 8;
      ppn = 44'({$urandom, $urandom});
      if ($urandom % 4 != 0) ppn[17:0] = '0;
      if (kind == 0) begin
        t_pte[s] = ($urandom % 2) ? mk_pte(ppn, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0)
                                  : mk_pte(ppn, 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 1'b0, 1'b1);
      end else if (kind < 4) begin
        t_pte[s] = mk_pte(ppn, 1'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      end else begin
        case ($urandom % 5)
          0: rwx = 3'b001; 1: rwx = 3'b011; 2: rwx = 3'b100; 3: rwx = 3'b101;
          default: rwx = 3'b111;
        endcase
        t_pte[s] = mk_pte(ppn, 1'($urandom), 1'($urandom), rwx[2], rwx[1], rwx[0], 1'b1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {63'd0, busy}, 64'd0);
    chk("R10 reset done", {63'd0, done}, 64'd0);
    chk("R9 reset no read", {63'd0, mem_rd_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: pointer found at level 0
    set_req(39'h12_3456_789A, 2'b01, 1'b1, 1'b0, 1'b0, 56'h80_0000, 2'd0, 7);
    t_pte[0] = mk_pte(44'h123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_walk(0);

    // R3 R6 R7: full three-level walk, global from the top pointer
    set_req(39'h5A_BCDE_F123, 2'b01, 1'b0, 1'b0, 1'b0, 56'h1_0000, 2'd2, 7);
    t_pte[0] = mk_pte(44'h200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    t_pte[1] = mk_pte(44'h300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    t_pte[2] = mk_pte(44'hABCDE, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    run_walk(0);

    // R5: level-2 superpage with a stray low PPN bit
    set_req(39'h7F_FFFF_F000, 2'b10, 1'b1, 1'b0, 1'b0, 56'h4000, 2'd2, 7);
    t_pte[0] = mk_pte(44'h4_0001_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    run_walk(0);

    // R6: aligned level-1 superpage merges the low VPN bits
    set_req(39'h40_1357_9ABC, 2'b00, 1'b1, 1'b0, 1'b0, 56'h8000, 2'd1, 7);
    t_pte[0] = mk_pte(44'hF_FE00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    run_walk(0);

    // R8: error response on the second read
    set_req(39'h01_2345_6789, 2'b01, 1'b1, 1'b0, 1'b0, 56'h2000, 2'd2, 1);
    t_pte[0] = mk_pte(44'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    t_pte[1] = mk_pte(44'h66, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_walk(0);

    // R4: supervisor fetch from a user page, even with SUM set
    set_req(39'h00_0000_1000, 2'b00, 1'b1, 1'b0, 1'b1, 56'h3000, 2'd0, 7);
    t_pte[0] = mk_pte(44'h777, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    run_walk(0);

    // R4: execute-only load, MXR clear then set
    set_req(39'h00_0000_2ABC, 2'b01, 1'b1, 1'b0, 1'b0, 56'h3000, 2'd0, 7);
    t_pte[0] = mk_pte(44'h888, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    run_walk(0);
    set_req(39'h00_0000_2ABC, 2'b01, 1'b1, 1'b1, 1'b0, 56'h3000, 2'd0, 7);
    run_walk(0);

    // R4: supervisor load from a user page needs SUM
    set_req(39'h00_0000_3111, 2'b01, 1'b1, 1'b0, 1'b1, 56'h3000, 2'd0, 7);
    t_pte[0] = mk_pte(44'h999, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_walk(0);
    set_req(39'h00_0000_3111, 2'b01, 1'b1, 1'b0, 1'b0, 56'h3000, 2'd0, 7);
    run_walk(0);

    // R2: write without read is reserved
    set_req(39'h00_0000_4000, 2'b10, 1'b1, 1'b0, 1'b0, 56'h3000, 2'd0, 7);
    t_pte[0] = mk_pte(44'hAAA, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    run_walk(0);

    // R9: start during a walk has no effect
    set_req(39'h33_2211_0FED, 2'b10, 1'b1, 1'b0, 1'b0, 56'h9000, 2'd1, 7);
    t_pte[0] = mk_pte(44'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    t_pte[1] = mk_pte(44'h5678, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    run_walk(1);

    // R1: a starting level of 3 acts as 2
    set_req(39'h7F_0000_0000, 2'b01, 1'b1, 1'b0, 1'b0, 56'h5000, 2'd3, 7);
    t_pte[0] = mk_pte(44'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_walk(0);

    for (int n = 0; n < 400; n++) begin
      gen_random();
      run_walk(n % 7 == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule